// File: doc/BRIEF.md
# UART receive queue controller

This block takes the bytes that a UART receiver hands over and writes them into a buffer in RAM, so the CPU does not have to move each byte. The CPU loads a buffer address pointer and a remaining-byte count, then sets the start bit. Each byte that arrives while reception is active goes out on a memory write port. A write completes when the memory accepts it, and that same cycle moves the pointer up by one and the count down by one. When the count reaches zero, reception ends by itself and the reception flag rises. If the address-reset mode is on, the pointer also returns to 0 at that point, which keeps a circular buffer at address 0.

A halt bit stops storage without ending reception. A byte that has already been accepted still lands in RAM. Every byte that arrives later is thrown away until the CPU clears halt, and the start bit stays set the whole time. The reception flag can also be raised on every stored byte, or on stored bytes equal to a programmed match character. Software must clear the flag before the next event can be seen as a new 0-to-1 edge.

Byte traffic uses valid/ready on both sides. On the receive side, `rx_ready` is high whenever no memory write is waiting. A byte is taken in any cycle where `rx_valid` and `rx_ready` are both high. A byte taken while reception is inactive, halted or out of count is consumed and dropped. On the memory side, `mem_valid` holds address and data steady until `mem_ready` is seen. No new byte is accepted while a write is waiting.

Top module: `rxq_ctrl`

## Requirements
- R1: After reset, `ctl_rdata` is 0, `rx_flag` is 0, `ptr_o` and `cnt_o` are 0, `mem_valid` is 0 and `rx_ready` is 1.
- R2: A control write (`ctl_we`) uses this bit map: bit0 is start, bit1 is halt, bit2 is address reset, bit3 is match enable and bit4 is per-byte flag enable. Writing 1 to bit0 sets start and writing 0 to it has no effect. Bits 1 to 4 take the written value. `ctl_rdata` returns the same bit positions.
- R3: A byte accepted while start=1, halt=0, `uart_ren`=1 and count≠0 appears on the next cycle as `mem_valid`=1, with `mem_addr` equal to the pointer and `mem_data` equal to the byte. Address and data hold until `mem_ready`.
- R4: In the cycle where `mem_valid` and `mem_ready` are both high, the pointer increments and the count decrements. The new values show on the following cycle. A CPU load through `ptr_we` or `cnt_we` in the same cycle takes priority.
- R5: A completed write that brings the count from 1 to 0 clears start and sets `rx_flag`. A CPU start write in that same cycle keeps start set.
- R6: At that end of buffer the pointer becomes 0 when address reset is 1. Otherwise it becomes the old pointer plus 1, wrapping modulo 2^AW.
- R7: A byte accepted while halt=1 is dropped: no write, and pointer and count do not change. A write already waiting still completes, and start stays 1.
- R8: While `uart_ren` is 0, start is forced to 0 on the next edge and a CPU start write is ignored.
- R9: With match enable on, a completed write whose byte equals `match_char` sets `rx_flag`. Other bytes do not set it.
- R10: With per-byte enable on, every completed write sets `rx_flag`.
- R11: `flag_clr` clears `rx_flag`. A set event in the same cycle wins, so the flag stays 1.
- R12: `rx_ready` is 0 exactly while a memory write is waiting. A byte offered while reception is inactive is still consumed and produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control write data (see R2) |
| ctl_rdata | output | 5 | Control bits readback, start in bit0 |
| flag_clr | input | 1 | CPU clear of the reception flag |
| ptr_we | input | 1 | Load strobe for the address pointer |
| ptr_wdata | input | AW | Address pointer load value |
| cnt_we | input | 1 | Load strobe for the byte count |
| cnt_wdata | input | CW | Byte count load value |
| match_char | input | 8 | Character compared against stored bytes |
| uart_ren | input | 1 | UART receive enable |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Block can take a byte |
| rx_data | input | 8 | Received byte |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | AW | Write address |
| mem_data | output | 8 | Write data |
| rx_flag | output | 1 | Reception interrupt flag |
| ptr_o | output | AW | Current address pointer |
| cnt_o | output | CW | Remaining byte count |

## Verification
The bench builds the block with AW=6 and CW=4. A 4-bit count lets random runs reach end of buffer every few bytes. A 64-byte address space lets the plain pointer wrap past 63 and the address-reset reload both occur within a short run. The match character is drawn from the same small set of values as the received bytes, so match hits occur often. `mem_ready` stalls in random cycles, so back-pressure overlaps halt, flag clears and enable drops.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int CTL_W    = 5;
  localparam int START_B  = 0;
  localparam int HALT_B   = 1;
  localparam int ARST_B   = 2;
  localparam int MEN_B    = 3;
  localparam int PBI_B    = 4;

  typedef struct packed {
    logic per_byte;
    logic match_en;
    logic addr_rst;
    logic halt;
  } rxq_mode_t;
endpackage

// File: rtl/rxq_ctl_regs.sv
module rxq_ctl_regs
  import rxq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             uart_ren,
  input  logic             end_evt,
  input  logic             byte_irq,
  input  logic             flag_clr,
  output rxq_mode_t        mode,
  output logic             start_q,
  output logic             flag_q
);
  logic set_start;
  logic flag_set;

  assign set_start = ctl_we && ctl_wdata[START_B];
  assign flag_set  = end_evt || byte_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
    end else if (ctl_we) begin
      mode.halt     <= ctl_wdata[HALT_B];
      mode.addr_rst <= ctl_wdata[ARST_B];
      mode.match_en <= ctl_wdata[MEN_B];
      mode.per_byte <= ctl_wdata[PBI_B];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          start_q <= 1'b0;
    else if (!uart_ren)  start_q <= 1'b0;
    else if (set_start)  start_q <= 1'b1;
    else if (end_evt)    start_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (flag_set)  flag_q <= 1'b1;
    else if (flag_clr)  flag_q <= 1'b0;
  end

  // R8
  a_r8_ren_clears_start: assert property (@(posedge clk) disable iff (!rst_n)
    !uart_ren |=> !start_q);
  // R5
  a_r5_end_clears_start: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt && !(ctl_we && ctl_wdata[START_B])) |=> !start_q);
  // R11
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_irq && flag_clr) |=> flag_q);
endmodule

// File: rtl/rxq_buf_ptr.sv
module rxq_buf_ptr #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_we,
  input  logic [AW-1:0] ptr_wdata,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_wdata,
  input  logic          fire,
  input  logic          addr_rst,
  output logic [AW-1:0] ptr_q,
  output logic [CW-1:0] cnt_q,
  output logic          end_evt,
  output logic          cnt_nz
);
  localparam logic [AW-1:0] PTR_ONE = AW'(1);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [AW-1:0] ptr_step;

  assign end_evt  = fire && (cnt_q == CNT_ONE);
  assign cnt_nz   = (cnt_q != '0);
  assign ptr_step = (end_evt && addr_rst) ? '0 : ptr_q + PTR_ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_we) ptr_q <= ptr_wdata;
    else if (fire)   ptr_q <= ptr_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_wdata;
    else if (fire)   cnt_q <= cnt_q - CNT_ONE;
  end

  // R4
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cnt_we) |=> (cnt_q == $past(cnt_q) - CNT_ONE));
  // R6
  a_r6_addr_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cnt_q == CNT_ONE && addr_rst && !ptr_we) |=> (ptr_q == '0));
endmodule

// File: rtl/rxq_wr_stage.sv
module rxq_wr_stage #(
  parameter int AW        = 16,
  parameter bit HAS_MATCH = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          rx_ready,
  input  logic          can_store,
  input  logic [AW-1:0] ptr,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_data,
  input  logic          match_en,
  input  logic          per_byte,
  input  logic [7:0]    match_char,
  output logic          fire,
  output logic          byte_irq
);
  logic take;
  logic store;
  logic hit;

  assign rx_ready = !mem_valid;
  assign take     = rx_valid && rx_ready;
  assign store    = take && can_store;
  assign fire     = mem_valid && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else if (store) begin
      mem_valid <= 1'b1;
      mem_addr  <= ptr;
      mem_data  <= rx_data;
    end else if (fire) begin
      mem_valid <= 1'b0;
    end
  end

  generate
    if (HAS_MATCH) begin : g_match
      assign hit = match_en && (mem_data == match_char);
    end else begin : g_nomatch
      assign hit = 1'b0;
    end
  endgenerate

  assign byte_irq = fire && (per_byte || hit);

  // R3
  a_r3_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));
  // R7
  a_r7_dropped_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !can_store) |=> !mem_valid);
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int AW        = 16,
  parameter int CW        = 16,
  parameter bit HAS_MATCH = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             flag_clr,
  input  logic             ptr_we,
  input  logic [AW-1:0]    ptr_wdata,
  input  logic             cnt_we,
  input  logic [CW-1:0]    cnt_wdata,
  input  logic [7:0]       match_char,
  input  logic             uart_ren,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [7:0]       rx_data,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_data,
  output logic             rx_flag,
  output logic [AW-1:0]    ptr_o,
  output logic [CW-1:0]    cnt_o
);
  rxq_mode_t mode;
  logic      start_q;
  logic      end_evt;
  logic      byte_irq;
  logic      fire;
  logic      cnt_nz;
  logic      can_store;

  assign can_store = start_q && !mode.halt && uart_ren && cnt_nz;
  assign ctl_rdata = {mode.per_byte, mode.match_en, mode.addr_rst, mode.halt, start_q};

  rxq_ctl_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_we   (ctl_we),
    .ctl_wdata(ctl_wdata),
    .uart_ren (uart_ren),
    .end_evt  (end_evt),
    .byte_irq (byte_irq),
    .flag_clr (flag_clr),
    .mode     (mode),
    .start_q  (start_q),
    .flag_q   (rx_flag)
  );

  rxq_buf_ptr #(.AW(AW), .CW(CW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptr_we   (ptr_we),
    .ptr_wdata(ptr_wdata),
    .cnt_we   (cnt_we),
    .cnt_wdata(cnt_wdata),
    .fire     (fire),
    .addr_rst (mode.addr_rst),
    .ptr_q    (ptr_o),
    .cnt_q    (cnt_o),
    .end_evt  (end_evt),
    .cnt_nz   (cnt_nz)
  );

  rxq_wr_stage #(.AW(AW), .HAS_MATCH(HAS_MATCH)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_ready  (rx_ready),
    .can_store (can_store),
    .ptr       (ptr_o),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .match_en  (mode.match_en),
    .per_byte  (mode.per_byte),
    .match_char(match_char),
    .fire      (fire),
    .byte_irq  (byte_irq)
  );
endmodule

// File: tb/rxq_ctrl_tb_top.sv
module rxq_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int AW = 6;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 0, flag_clr = 0, ptr_we = 0, cnt_we = 0;
  logic [4:0] ctl_wdata = '0;
  logic [4:0] ctl_rdata;
  logic [AW-1:0] ptr_wdata = '0;
  logic [CW-1:0] cnt_wdata = '0;
  logic [7:0] match_char = '0, rx_data = '0, mem_data;
  logic uart_ren = 0, rx_valid = 0, mem_ready = 0;
  logic rx_ready, mem_valid, rx_flag;
  logic [AW-1:0] mem_addr, ptr_o;
  logic [CW-1:0] cnt_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state
  logic m_start, m_halt, m_ar, m_me, m_pb, m_flag, m_mv;
  logic [AW-1:0] m_ptr, m_maddr;
  logic [CW-1:0] m_cnt;
  logic [7:0] m_mdata;

  always #(CLK_P/2) clk = ~clk;

  rxq_ctrl #(.AW(AW), .CW(CW), .HAS_MATCH(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .flag_clr(flag_clr), .ptr_we(ptr_we),
    .ptr_wdata(ptr_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .match_char(match_char), .uart_ren(uart_ren), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .rx_flag(rx_flag), .ptr_o(ptr_o), .cnt_o(cnt_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    {m_start, m_halt, m_ar, m_me, m_pb, m_flag, m_mv} = '0;
    m_ptr = '0; m_maddr = '0; m_cnt = '0; m_mdata = '0;
  endtask

  function automatic logic [4:0] exp_ctl();
    return {m_pb, m_me, m_ar, m_halt, m_start};
  endfunction

  // one clock: compute next reference state from current inputs, advance, compare
  task automatic cyc();
    logic rdy, store, fire, last, hit;
    logic n_start, n_flag, n_mv;
    logic [AW-1:0] n_ptr, n_maddr;
    logic [CW-1:0] n_cnt;
    logic [7:0] n_mdata;
    rdy   = !m_mv;
    store = rx_valid && rdy && m_start && !m_halt && uart_ren && (m_cnt != 0);
    fire  = m_mv && mem_ready;
    last  = fire && (m_cnt == CW'(1));
    hit   = last || (fire && (m_pb || (m_me && m_mdata == match_char)));
    n_mv = store ? 1'b1 : (fire ? 1'b0 : m_mv);
    n_maddr = store ? m_ptr : m_maddr;
    n_mdata = store ? rx_data : m_mdata;
    n_ptr = ptr_we ? ptr_wdata : (fire ? ((last && m_ar) ? '0 : m_ptr + AW'(1)) : m_ptr);
    n_cnt = cnt_we ? cnt_wdata : (fire ? m_cnt - CW'(1) : m_cnt);
    n_start = !uart_ren ? 1'b0 : ((ctl_we && ctl_wdata[0]) ? 1'b1 : (last ? 1'b0 : m_start));
    n_flag = hit ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
    if (ctl_we) {m_pb, m_me, m_ar, m_halt} = ctl_wdata[4:1];
    @(posedge clk); #1;
    m_mv = n_mv; m_maddr = n_maddr; m_mdata = n_mdata; m_ptr = n_ptr;
    m_cnt = n_cnt; m_start = n_start; m_flag = n_flag;
    chk("R3 mem_valid", mem_valid, m_mv);
    if (m_mv) begin
      chk("R3 mem_addr", mem_addr, m_maddr);
      chk("R3 mem_data", mem_data, m_mdata);
    end
    chk("R4 pointer", ptr_o, m_ptr);
    chk("R4 count", cnt_o, m_cnt);
    chk("R5 control readback", ctl_rdata, exp_ctl());
    chk("R11 flag", rx_flag, m_flag);
    chk("R12 rx_ready", rx_ready, !m_mv);
  endtask

  task automatic ctl_write(logic [4:0] v);
    ctl_we = 1; ctl_wdata = v; cyc(); ctl_we = 0;
  endtask

  task automatic load(logic [AW-1:0] p, logic [CW-1:0] c);
    ptr_we = 1; ptr_wdata = p; cnt_we = 1; cnt_wdata = c; cyc();
    ptr_we = 0; cnt_we = 0;
  endtask

  task automatic send(logic [7:0] b);
    rx_valid = 1; rx_data = b; cyc(); rx_valid = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h1F2E3D4C);
    model_reset();
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    chk("R1 ctl_rdata", ctl_rdata, 0);
    chk("R1 rx_flag", rx_flag, 0);
    chk("R1 ptr", ptr_o, 0);
    chk("R1 cnt", cnt_o, 0);
    chk("R1 mem_valid", mem_valid, 0);
    chk("R1 rx_ready", rx_ready, 1);

    uart_ren = 1;
    load(6'd10, 4'd3);
    ctl_write(5'b00001);
    chk("R2 start set", ctl_rdata, 5'b00001);

    // store with back-pressure
    mem_ready = 0;
    send(8'hA5);
    chk("R3 addr", mem_addr, 10);
    chk("R3 data", mem_data, 8'hA5);
    cyc(); cyc();
    chk("R12 ready low while waiting", rx_ready, 0);
    mem_ready = 1; cyc();
    chk("R4 ptr step", ptr_o, 11);
    chk("R4 cnt step", cnt_o, 2);

    // in-flight byte finishes under halt, later byte dropped
    mem_ready = 0;
    send(8'h22);
    ctl_write(5'b00011);
    mem_ready = 1; cyc();
    chk("R7 in-flight stored ptr", ptr_o, 12);
    send(8'h11);
    chk("R7 dropped no write", mem_valid, 0);
    cyc();
    chk("R7 cnt unchanged", cnt_o, 1);
    chk("R7 start kept", ctl_rdata[0], 1);

    // unhalt; writing 0 to start bit keeps it
    ctl_write(5'b00000);
    chk("R2 start write0 no effect", ctl_rdata[0], 1);
    send(8'h33); cyc();
    chk("R5 start cleared at end", ctl_rdata[0], 0);
    chk("R5 flag at end", rx_flag, 1);
    chk("R6 no reload ptr", ptr_o, 13);
    flag_clr = 1; cyc(); flag_clr = 0;
    chk("R11 cleared", rx_flag, 0);
    send(8'h44);
    chk("R12 inactive byte consumed no write", mem_valid, 0);

    // circular reload
    load(6'd62, 4'd2);
    ctl_write(5'b00101);
    send(8'h01); cyc();
    chk("R6 wrap step", ptr_o, 63);
    send(8'h02); cyc();
    chk("R6 address reset", ptr_o, 0);
    flag_clr = 1; cyc(); flag_clr = 0;

    // per-byte, set wins over clear
    load(6'd0, 4'd5);
    ctl_write(5'b10001);
    send(8'h07);
    flag_clr = 1; cyc(); flag_clr = 0;
    chk("R10 per-byte flag, R11 set wins", rx_flag, 1);
    flag_clr = 1; cyc(); flag_clr = 0;

    // match
    match_char = 8'h5A;
    ctl_write(5'b01001);
    send(8'h12); cyc();
    chk("R9 no match", rx_flag, 0);
    send(8'h5A); cyc();
    chk("R9 match", rx_flag, 1);

    // receive enable low
    uart_ren = 0; cyc();
    chk("R8 ren clears start", ctl_rdata[0], 0);
    ctl_write(5'b00001);
    chk("R8 start ignored", ctl_rdata[0], 0);
    send(8'h5A);
    chk("R8 no write", mem_valid, 0);
    uart_ren = 1;

    // random phase
    for (int i = 0; i < 6000; i++) begin
      uart_ren  = ($urandom % 40) != 0;
      rx_valid  = ($urandom % 2) == 0;
      rx_data   = 8'h58 + 8'($urandom % 4);
      mem_ready = ($urandom % 10) < 7;
      flag_clr  = ($urandom % 8) == 0;
      ctl_we    = ($urandom % 16) == 0;
      ctl_wdata = 5'($urandom) | 5'b00001;
      ctl_wdata[1] = ($urandom % 4) == 0;
      ptr_we    = ($urandom % 64) == 0;
      ptr_wdata = AW'($urandom);
      cnt_we    = ($urandom % 12) == 0;
      cnt_wdata = CW'($urandom);
      if (($urandom % 100) == 0) match_char = 8'h58 + 8'($urandom % 4);
      cyc();
    end
    {ctl_we, flag_clr, ptr_we, cnt_we, rx_valid} = '0;

    done = 1;
    summary();
    $finish;
  end
endmodule